// File: doc/BRIEF.md
# Clock Source Selection Controller

This block decides which source drives the CPU clock. Three sources exist: an internal high-speed oscillator, which is used out of reset, a main source, and a subsystem source. The main and subsystem sources can each be a crystal or an external clock input. Software programs the block through a small byte-wide register file. It holds a mode register that can be written only once, a pair of stop bits, a stabilization threshold, a read-only stabilization status, and the select bits. The block also checks every switch request and refuses any switch to a source that is not yet usable.

The oscillators are not modelled here. Each source has an enable output and a tick input, and each tick stands for one source clock cycle. The block counts these ticks to find out how long a crystal has been running. The glitch-free clock multiplexer is also outside the block. The controller drives a 2-bit select code to it. That code changes only in the cycle after a registered update strobe, so the order of a switch can be followed cycle by cycle.

Register addresses:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | stop control |
| 2 | threshold |
| 3 | main status |
| 4 | select |

Any other address reads 0.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, the registers read as follows: mode 0x00, stop control 0x03 (bit0 is the main stop bit, bit1 is the sub stop bit, and both are set), threshold 1, status 0x00, select 0x00. In the same state, clk_sel is 2'b00 (internal oscillator), both oscillator enables are 0 and sel_update is 0.
- R2: The mode register takes the first write to address 0 after reset. Every later write to it is ignored until the next reset. Its layout is: bits [1:0] are the main pair {ext, osc}, bit 2 is the main range, bits [5:4] are the sub pair {ext, osc} and bits [7:6] are the sub drive.
- R3: In a source pair, the value 01 means crystal and 11 means external clock. A select request for a source whose pair is neither of these is refused.
- R4: While the main source is enabled, one more status bit is set from the LSB upward after every 2^CNT_LOG2 main ticks. The status clears in the cycle after the main stop bit is set.
- R5: A request to select a main crystal (select bit0 written as 1) is accepted only if the main source is started and the number of set status bits is at least the threshold. A refused request leaves bit0 at 0 and sets the error flag, which is select bit7.
- R6: A request to select an external main clock is accepted as soon as its stop bit is 0, with no stabilization wait.
- R7: A request to select the sub source (select bit1) follows the same rules. It uses the sub source's own tick count against the same threshold, and an external sub clock needs no wait.
- R8: A write that tries to set a stop bit is ignored for that bit while the matching select bit is 1.
- R9: Each write to the select register raises sel_update for one cycle, and clk_sel changes only in the cycle after that. The codes are 00 for the internal oscillator, 01 for main and 10 for sub. Sub takes priority over main.
- R10: A write to the select register that is fully accepted clears the error flag.
- R11: Each oscillator enable output is the inverse of its stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| main_tick | input | 1 | One main source cycle elapsed |
| sub_tick | input | 1 | One sub source cycle elapsed |
| main_osc_en | output | 1 | Main oscillator or input buffer enable |
| sub_osc_en | output | 1 | Sub oscillator or input buffer enable |
| clk_sel | output | 2 | Source code for the external clock multiplexer |
| sel_update | output | 1 | Registered strobe that precedes a clk_sel change |

## Verification
The assertions assume that at most one register write happens per cycle. They also assume that tick inputs are single-cycle samples of a source that is already running. They do not assume any relation between ticks and the enable outputs. The bench changes inputs only on the falling edge. It raises ticks only after the matching stop bit has been cleared. Every reset it applies lasts at least two cycles, so the assertions never see a half-initialised state.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10
  } src_e;

  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_STOP = 3'd1;
  localparam logic [2:0] ADR_THR  = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_SEL  = 3'd4;

  // a pair {ext, osc} names a usable source when osc is set
  function automatic logic pair_valid(input logic [1:0] p);
    return p[0];
  endfunction

  function automatic logic pair_is_ext(input logic [1:0] p);
    return p == 2'b11;
  endfunction

  // sub wins over main, main wins over the internal oscillator
  function automatic src_e pick_src(input logic main_sel, input logic sub_sel);
    if (sub_sel)       return SRC_SUB;
    else if (main_sel) return SRC_MAIN;
    else               return SRC_INT;
  endfunction

endpackage

// File: rtl/clk_stab_counter.sv
module clk_stab_counter #(
  parameter int STAT_W   = 8,
  parameter int CNT_LOG2 = 4,
  parameter int LVL_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              is_ext,
  input  logic [LVL_W-1:0]  thr,
  output logic [STAT_W-1:0] therm,
  output logic              ready
);

  logic [CNT_LOG2-1:0] cnt_q;
  logic [STAT_W-1:0]   therm_q;
  logic [LVL_W-1:0]    level;

  function automatic logic [LVL_W-1:0] therm_level(input logic [STAT_W-1:0] t);
    logic [LVL_W-1:0] n;
    n = '0;
    for (int i = 0; i < STAT_W; i++) n = n + LVL_W'(t[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q   <= '0;
      therm_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) therm_q <= {therm_q[STAT_W-2:0], 1'b1};
    end
  end

  assign level = therm_level(therm_q);
  assign therm = therm_q;
  assign ready = en && (is_ext || (level >= thr));

  // R4
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm_q + 1'b1) & therm_q) == '0);

  // R4
  therm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (therm_q == '0));

endmodule

// File: rtl/clk_sel_arbiter.sv
module clk_sel_arbiter
  import clk_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic       req_main,
  input  logic       req_sub,
  input  logic       rdy_main,
  input  logic       rdy_sub,
  output logic       main_sel,
  output logic       sub_sel,
  output logic       err,
  output logic [1:0] clk_sel,
  output logic       sel_update
);

  logic main_sel_q, sub_sel_q, err_q, upd_q;
  src_e cur_q;
  logic refuse_main, refuse_sub;

  assign refuse_main = wr_sel && req_main && !rdy_main;
  assign refuse_sub  = wr_sel && req_sub  && !rdy_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_sel_q <= 1'b0;
      sub_sel_q  <= 1'b0;
      err_q      <= 1'b0;
      upd_q      <= 1'b0;
      cur_q      <= SRC_INT;
    end else begin
      upd_q <= wr_sel;
      if (wr_sel) begin
        main_sel_q <= req_main && rdy_main;
        sub_sel_q  <= req_sub && rdy_sub;
        err_q      <= refuse_main || refuse_sub;
      end
      if (upd_q) cur_q <= pick_src(main_sel_q, sub_sel_q);
    end
  end

  assign main_sel   = main_sel_q;
  assign sub_sel    = sub_sel_q;
  assign err        = err_q;
  assign clk_sel    = cur_q;
  assign sel_update = upd_q;

  // R5
  refuse_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_main |=> (!main_sel_q && err_q));

  // R7
  refuse_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_sub |=> (!sub_sel_q && err_q));

  // R9
  sel_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> $stable(cur_q));

  // R5
  main_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_sel_q) |-> $past(rdy_main));

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int CNT_LOG2 = 4,
  parameter int THR_RST  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       main_tick,
  input  logic       sub_tick,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic [1:0] clk_sel,
  output logic       sel_update
);

  localparam int LVL_W = $clog2(STAT_W + 1);

  logic [7:0]       mode_q;
  logic             mode_lock_q;
  logic             main_stop_q, sub_stop_q;
  logic [LVL_W-1:0] thr_q;
  logic             main_sel, sub_sel, sel_err;

  logic             wr_mode, wr_stop, wr_thr, wr_sel;
  logic [1:0]       main_pair, sub_pair;

  logic [1:0]       src_en, src_tick, src_ext, src_rdy;
  logic [STAT_W-1:0] src_therm [2];

  assign wr_mode = wr_en && (addr == ADR_MODE);
  assign wr_stop = wr_en && (addr == ADR_STOP);
  assign wr_thr  = wr_en && (addr == ADR_THR);
  assign wr_sel  = wr_en && (addr == ADR_SEL);

  assign main_pair = mode_q[1:0];
  assign sub_pair  = mode_q[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      mode_lock_q <= 1'b0;
      main_stop_q <= 1'b1;
      sub_stop_q  <= 1'b1;
      thr_q       <= LVL_W'(THR_RST);
    end else begin
      if (wr_mode && !mode_lock_q) begin
        mode_q      <= wdata;
        mode_lock_q <= 1'b1;
      end
      if (wr_stop) begin
        main_stop_q <= wdata[0] && !main_sel;
        sub_stop_q  <= wdata[1] && !sub_sel;
      end
      if (wr_thr) thr_q <= wdata[LVL_W-1:0];
    end
  end

  assign src_en   = {!sub_stop_q, !main_stop_q};
  assign src_tick = {sub_tick, main_tick};
  assign src_ext  = {pair_is_ext(sub_pair), pair_is_ext(main_pair)};

  for (genvar g = 0; g < 2; g++) begin : g_stab
    clk_stab_counter #(
      .STAT_W   (STAT_W),
      .CNT_LOG2 (CNT_LOG2),
      .LVL_W    (LVL_W)
    ) u_stab (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (src_en[g]),
      .tick   (src_tick[g]),
      .is_ext (src_ext[g]),
      .thr    (thr_q),
      .therm  (src_therm[g]),
      .ready  (src_rdy[g])
    );
  end

  clk_sel_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (wr_sel),
    .req_main   (wdata[0]),
    .req_sub    (wdata[1]),
    .rdy_main   (src_rdy[0] && pair_valid(main_pair)),
    .rdy_sub    (src_rdy[1] && pair_valid(sub_pair)),
    .main_sel   (main_sel),
    .sub_sel    (sub_sel),
    .err        (sel_err),
    .clk_sel    (clk_sel),
    .sel_update (sel_update)
  );

  always_comb begin
    case (addr)
      ADR_MODE: rdata = mode_q;
      ADR_STOP: rdata = {6'b0, sub_stop_q, main_stop_q};
      ADR_THR:  rdata = 8'(thr_q);
      ADR_STAT: rdata = 8'(src_therm[0]);
      ADR_SEL:  rdata = {sel_err, 5'b0, sub_sel, main_sel};
      default:  rdata = 8'h00;
    endcase
  end

  assign main_osc_en = src_en[0];
  assign sub_osc_en  = src_en[1];

  // R2
  mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && mode_lock_q) |=> $stable(mode_q));

  // R8
  main_stop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_sel |-> !main_stop_q);

  // R8
  sub_stop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_sel |-> !sub_stop_q);

endmodule

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic       main_osc_en, sub_osc_en;
  logic [1:0] clk_sel;
  logic       sel_update;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  clk_src_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .main_tick(main_tick), .sub_tick(sub_tick),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
    .clk_sel(clk_sel), .sel_update(sel_update)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input bit use_sub, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_sub) sub_tick = 1'b1; else main_tick = 1'b1;
    end
    @(negedge clk);
    main_tick = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(3'd0, d); chk("R1 mode", d, 8'h00);
    rd(3'd1, d); chk("R1 stop", d, 8'h03);
    rd(3'd2, d); chk("R1 thr", d, 8'h01);
    rd(3'd3, d); chk("R1 stat", d, 8'h00);
    rd(3'd4, d); chk("R1 sel", d, 8'h00);
    chk("R1 clk_sel", {6'b0, clk_sel}, 8'h00);
    chk("R1 osc_en", {6'b0, sub_osc_en, main_osc_en}, 8'h00);
    chk("R1 sel_update", {7'b0, sel_update}, 8'h00);
  endtask

  task automatic t_mode_lock();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R2 first write", d, 8'h01);
    wr(3'd0, 8'hFE);
    rd(3'd0, d); chk("R2 second write ignored", d, 8'h01);
  endtask

  task automatic t_main_crystal();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h02);
    rd(3'd2, d); chk("R5 thr", d, 8'h02);
    wr(3'd1, 8'h02);
    chk("R11 enables after start", {6'b0, sub_osc_en, main_osc_en}, 8'h01);
    ticks(1'b0, 15);
    rd(3'd3, d); chk("R4 stat before period", d, 8'h00);
    ticks(1'b0, 1);
    rd(3'd3, d); chk("R4 stat one period", d, 8'h01);
    wr(3'd4, 8'h01);
    chk("R9 strobe on refused write", {7'b0, sel_update}, 8'h01);
    rd(3'd4, d); chk("R5 early request refused", d, 8'h80);
    chk("R5 clk_sel stays internal", {6'b0, clk_sel}, 8'h00);
    ticks(1'b0, 16);
    rd(3'd3, d); chk("R4 stat two periods", d, 8'h03);
    wr(3'd4, 8'h01);
    chk("R9 clk_sel not yet moved", {6'b0, clk_sel}, 8'h00);
    chk("R9 strobe", {7'b0, sel_update}, 8'h01);
    rd(3'd4, d); chk("R10 accepted clears err", d, 8'h01);
    chk("R9 clk_sel main", {6'b0, clk_sel}, 8'h01);
    chk("R9 strobe one cycle", {7'b0, sel_update}, 8'h00);
    wr(3'd1, 8'h03);
    rd(3'd1, d); chk("R8 main stop ignored", d, 8'h02);
    chk("R11 main stays enabled", {7'b0, main_osc_en}, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R9 deselect", d, 8'h00);
    chk("R9 clk_sel internal", {6'b0, clk_sel}, 8'h00);
    wr(3'd1, 8'h03);
    rd(3'd3, d); chk("R4 stat cleared on stop", d, 8'h00);
    chk("R11 main disabled", {7'b0, main_osc_en}, 8'h00);
  endtask

  task automatic t_bad_pair();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h02);
    ticks(1'b0, 32);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R3 pair 00 refused", d, 8'h80);
  endtask

  task automatic t_main_ext();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R6 stopped source refused", d, 8'h80);
    wr(3'd1, 8'h02);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R6 external accepted without wait", d, 8'h01);
    chk("R6 clk_sel main", {6'b0, clk_sel}, 8'h01);
  endtask

  task automatic t_sub();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h01);
    chk("R11 sub enable", {6'b0, sub_osc_en, main_osc_en}, 8'h02);
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk("R7 sub early refused", d, 8'h80);
    ticks(1'b1, 16);
    rd(3'd3, d); chk("R4 sub ticks leave main stat", d, 8'h00);
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk("R7 sub accepted", d, 8'h02);
    chk("R7 clk_sel sub", {6'b0, clk_sel}, 8'h02);
    wr(3'd1, 8'h03);
    rd(3'd1, d); chk("R8 sub stop ignored", d, 8'h01);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h33);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h03);
    rd(3'd4, d); chk("R7 both external accepted", d, 8'h03);
    chk("R9 sub has priority", {6'b0, clk_sel}, 8'h02);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R9 back to main", {6'b0, clk_sel}, 8'h01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_mode_lock();
        t_main_crystal();
        t_bad_pair();
        t_main_ext();
        t_sub();
        t_priority();
      end
      begin
        wait (cycles >= WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule